// File: doc/BRIEF.md
# Parallel Bus Read Sequencer

This block runs read cycles, single or burst, on a multiplexed external parallel bus that connects to memory-like devices such as NOR flash or an FPGA. A request gives a start address and a beat count. The sequencer then runs a fixed sequence. First it drives the address on the shared address/data lines while an address-latch strobe is high. Next it releases the lines and asserts chip select. Output enable follows after a programmed setup delay. The sequencer samples the data lines at programmed instants and returns each sampled beat on a one-cycle valid/data stream.

Every phase of the waveform is a separate register input counted in clock ticks: setup, first access, next access, hold and turnaround. Output enable and chip select are released by different rules. Output enable always drops right after the final sample. Chip select lingers for the hold time. A turnaround gap then keeps the block from driving the shared lines again until a slow device has let go of them. A consistency check on the timing inputs blocks new requests when the setup or hold ordering is broken.

Top module: `pbus_rd_seq`

## Requirements
- R1: A request is taken at a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high only while the sequencer is idle, the turnaround gap has expired and `cfg_err_o` is low. `busy_o` is high from the cycle after acceptance until the gap has expired.
- R2: In the cycle after acceptance, `bus_ale_o` and `bus_ad_oe_o` are high for exactly one cycle and `bus_ad_o` equals `req_addr_i`. Both are low in every other cycle.
- R3: `bus_cs_o` rises in the cycle after acceptance. `bus_oe_o` rises `cfg_rd_setup_i` cycles later, which is the same cycle when the setting is 0. The setup value does not move any sample point.
- R4: Counting the accepting edge as edge 0, the first sample of `bus_ad_i` is taken at edge 1 + `cfg_acc_first_i`. After each sample edge, `rsp_valid_o` is high for one cycle and carries the sampled value.
- R5: A burst has `req_beats_i` + 1 beats. Consecutive samples are `cfg_acc_next_i` edges apart, and a value of 0 is treated as 1. `rsp_last_o` is high only together with the final beat.
- R6: `bus_oe_o` is low from the cycle that follows the final sample edge, whatever the hold setting.
- R7: `bus_cs_o` falls `cfg_rd_hold_i` cycles after `bus_oe_o` falls. With a hold of 0, both fall in the same cycle.
- R8: When the final sample is at edge S, the earliest edge that can accept a new request is S + `cfg_turn_off_i`. `bus_ad_oe_o` therefore stays low for at least `cfg_turn_off_i` cycles after the final sample.
- R9: `bus_a_o` shows `req_addr_i[2:0]` from the cycle after acceptance. After each non-final sample it advances, modulo 8, by 1 when `cfg_bus16_i` = 0 (8-bit bus) or by 2 when `cfg_bus16_i` = 1 (16-bit bus).
- R10: With `cfg_bus16_i` = 0, `rsp_data_o` holds `bus_ad_i[7:0]` in bits 7:0 and zeros above them. With `cfg_bus16_i` = 1, it holds all of `bus_ad_i`.
- R11: `cfg_err_o` is high when `cfg_rd_setup_i` >= `cfg_acc_first_i` or when `cfg_rd_hold_i` >= `cfg_turn_off_i`. While it is high no request is accepted, and the bus strobes and `busy_o` stay low.
- R12: The timing settings and bus width are captured at acceptance. Changing them during a transfer does not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_acc_first_i | input | TW | Ticks from the end of the ALE cycle to the first sample |
| cfg_acc_next_i | input | TW | Ticks between burst samples (0 acts as 1) |
| cfg_rd_setup_i | input | TW | Ticks from chip select to output enable |
| cfg_rd_hold_i | input | TW | Ticks from output-enable release to chip-select release |
| cfg_turn_off_i | input | TW | Turnaround ticks after the final sample |
| cfg_bus16_i | input | 1 | 1: 16-bit data bus, 0: 8-bit data bus |
| cfg_err_o | output | 1 | Timing settings violate the setup or hold ordering |
| req_valid_i | input | 1 | Read request present |
| req_addr_i | input | DATA_W | Start address |
| req_beats_i | input | BEAT_W | Beat count minus one |
| req_ready_o | output | 1 | Request can be taken this cycle |
| busy_o | output | 1 | Transfer or turnaround in progress |
| bus_ale_o | output | 1 | Address-latch strobe, active high |
| bus_cs_o | output | 1 | Chip select, active high |
| bus_oe_o | output | 1 | Output enable, active high |
| bus_a_o | output | 3 | Low address bits, stepped per beat |
| bus_ad_o | output | DATA_W | Address driven on the shared lines |
| bus_ad_oe_o | output | 1 | Drive enable for the shared lines |
| bus_ad_i | input | DATA_W | Data read from the shared lines |
| rsp_valid_o | output | 1 | Sampled beat valid (one cycle) |
| rsp_data_o | output | DATA_W | Sampled beat |
| rsp_last_o | output | 1 | Final beat of the burst |

## Verification
The bench builds the block with its default parameters: a 16-bit data path, 8-bit timing fields and a 4-bit beat count. Small timing values of 0 to 4 ticks are enough to reach every ordering the requirements name. These include a setup of 0, a hold of 0, a next-access value of 0 and the minimal turnaround of 1. Bursts of up to 16 beats let the three stepped address bits wrap in both bus widths. The data lines carry a per-cycle pattern, so each returned beat shows exactly which edge sampled it.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ALE  = 2'd1,
    ST_ACC  = 2'd2,
    ST_HOLD = 2'd3
  } rd_state_e;

  localparam int unsigned LOW_A_W  = 3;
  localparam int unsigned NARROW_W = 8;
endpackage

// File: rtl/pbus_tick_cnt.sv
// Load-or-count-down timer; stops at zero.
module pbus_tick_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         one_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign one_o  = (cnt_q == W'(1));
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pbus_cfg_chk.sv
module pbus_cfg_chk #(
  parameter int unsigned TW = 8
) (
  input  logic [TW-1:0] acc_first_i,
  input  logic [TW-1:0] rd_setup_i,
  input  logic [TW-1:0] rd_hold_i,
  input  logic [TW-1:0] turn_off_i,
  output logic          err_o
);
  assign err_o = (rd_setup_i >= acc_first_i) || (rd_hold_i >= turn_off_i);
endmodule

// File: rtl/pbus_addr_step.sv
module pbus_addr_step
  import pbus_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [LOW_A_W-1:0] start_i,
  input  logic               step_i,
  input  logic               wide_i,
  output logic [LOW_A_W-1:0] a_o
);
  logic [LOW_A_W-1:0] a_q;
  logic [LOW_A_W-1:0] inc;

  assign inc = wide_i ? LOW_A_W'(2) : LOW_A_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      a_q <= '0;
    else if (load_i)  a_q <= start_i;
    else if (step_i)  a_q <= a_q + inc;  // wraps modulo 8
  end

  assign a_o = a_q;
endmodule

// File: rtl/pbus_rd_seq.sv
module pbus_rd_seq
  import pbus_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TW     = 8,
  parameter int unsigned BEAT_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TW-1:0]       cfg_acc_first_i,
  input  logic [TW-1:0]       cfg_acc_next_i,
  input  logic [TW-1:0]       cfg_rd_setup_i,
  input  logic [TW-1:0]       cfg_rd_hold_i,
  input  logic [TW-1:0]       cfg_turn_off_i,
  input  logic                cfg_bus16_i,
  output logic                cfg_err_o,
  input  logic                req_valid_i,
  input  logic [DATA_W-1:0]   req_addr_i,
  input  logic [BEAT_W-1:0]   req_beats_i,
  output logic                req_ready_o,
  output logic                busy_o,
  output logic                bus_ale_o,
  output logic                bus_cs_o,
  output logic                bus_oe_o,
  output logic [LOW_A_W-1:0]  bus_a_o,
  output logic [DATA_W-1:0]   bus_ad_o,
  output logic                bus_ad_oe_o,
  input  logic [DATA_W-1:0]   bus_ad_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_data_o,
  output logic                rsp_last_o
);
  localparam int unsigned HI_W = DATA_W - NARROW_W;

  rd_state_e          st_q;
  logic               ale_q, cs_q, oe_q, ad_oe_q;
  logic [DATA_W-1:0]  ad_q;
  logic [BEAT_W-1:0]  beats_q;
  logic               rsp_valid_q, rsp_last_q;
  logic [DATA_W-1:0]  rsp_data_q;

  // timing captured at acceptance
  logic [TW-1:0]      af_q, an_q, hold_q, toff_q;
  logic               b16_q;

  logic               accept, sample, last_beat;
  logic               ph_load, ph_one, ph_zero;
  logic [TW-1:0]      ph_val, an_eff;
  logic               su_one, su_zero;
  logic               gap_zero, gap_one;
  logic [DATA_W-1:0]  narrow_data;

  pbus_cfg_chk #(.TW(TW)) u_cfg (
    .acc_first_i (cfg_acc_first_i),
    .rd_setup_i  (cfg_rd_setup_i),
    .rd_hold_i   (cfg_rd_hold_i),
    .turn_off_i  (cfg_turn_off_i),
    .err_o       (cfg_err_o)
  );

  assign req_ready_o = (st_q == ST_IDLE) && gap_zero && !cfg_err_o;
  assign busy_o      = (st_q != ST_IDLE) || !gap_zero;
  assign accept      = req_valid_i && req_ready_o;
  assign sample      = (st_q == ST_ACC) && ph_one;
  assign last_beat   = sample && (beats_q == '0);
  assign an_eff      = (an_q == '0) ? TW'(1) : an_q;

  // phase timer: first access, next access, hold
  always_comb begin
    ph_load = 1'b0;
    ph_val  = '0;
    if (st_q == ST_ALE) begin
      ph_load = 1'b1;
      ph_val  = af_q;
    end else if (last_beat) begin
      ph_load = 1'b1;
      ph_val  = hold_q;
    end else if (sample) begin
      ph_load = 1'b1;
      ph_val  = an_eff;
    end
  end

  pbus_tick_cnt #(.W(TW)) u_ph (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ph_load),
    .val_i  (ph_val),
    .one_o  (ph_one),
    .zero_o (ph_zero)
  );

  pbus_tick_cnt #(.W(TW)) u_su (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .val_i  (cfg_rd_setup_i),
    .one_o  (su_one),
    .zero_o (su_zero)
  );

  // turnaround; loaded one short so the accepting edge lands exactly on the limit
  pbus_tick_cnt #(.W(TW)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (last_beat),
    .val_i  (toff_q - TW'(1)),
    .one_o  (gap_one),
    .zero_o (gap_zero)
  );

  pbus_addr_step u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .start_i (req_addr_i[LOW_A_W-1:0]),
    .step_i  (sample && !last_beat),
    .wide_i  (b16_q),
    .a_o     (bus_a_o)
  );

  generate
    if (HI_W > 0) begin : g_narrow_pad
      assign narrow_data = {{HI_W{1'b0}}, bus_ad_i[NARROW_W-1:0]};
    end else begin : g_narrow_full
      assign narrow_data = bus_ad_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ale_q       <= 1'b0;
      cs_q        <= 1'b0;
      oe_q        <= 1'b0;
      ad_oe_q     <= 1'b0;
      ad_q        <= '0;
      beats_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_last_q  <= 1'b0;
      rsp_data_q  <= '0;
      af_q        <= '0;
      an_q        <= '0;
      hold_q      <= '0;
      toff_q      <= '0;
      b16_q       <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_last_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q    <= ST_ALE;
            ale_q   <= 1'b1;
            cs_q    <= 1'b1;
            ad_oe_q <= 1'b1;
            ad_q    <= req_addr_i;
            oe_q    <= (cfg_rd_setup_i == '0);
            beats_q <= req_beats_i;
            af_q    <= cfg_acc_first_i;
            an_q    <= cfg_acc_next_i;
            hold_q  <= cfg_rd_hold_i;
            toff_q  <= cfg_turn_off_i;
            b16_q   <= cfg_bus16_i;
          end
        end
        ST_ALE: begin
          ale_q   <= 1'b0;
          ad_oe_q <= 1'b0;
          st_q    <= ST_ACC;
          if (su_one) oe_q <= 1'b1;
        end
        ST_ACC: begin
          if (su_one) oe_q <= 1'b1;
          if (sample) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= b16_q ? bus_ad_i : narrow_data;
            rsp_last_q  <= last_beat;
            if (last_beat) begin
              oe_q <= 1'b0;
              if (hold_q == '0) begin
                cs_q <= 1'b0;
                st_q <= ST_IDLE;
              end else begin
                st_q <= ST_HOLD;
              end
            end else begin
              beats_q <= beats_q - 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (ph_one) begin
            cs_q <= 1'b0;
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_ale_o   = ale_q;
  assign bus_cs_o    = cs_q;
  assign bus_oe_o    = oe_q;
  assign bus_ad_o    = ad_q;
  assign bus_ad_oe_o = ad_oe_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign rsp_last_o  = rsp_last_q;

  // status-only counter outputs
  logic unused_flags;
  assign unused_flags = ph_zero ^ su_zero ^ gap_one;
endmodule

// File: rtl/pbus_rd_seq_chk.sv
module pbus_rd_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic cfg_err_o,
  input logic busy_o,
  input logic bus_ale_o,
  input logic bus_cs_o,
  input logic bus_oe_o,
  input logic bus_ad_oe_o,
  input logic rsp_valid_o
);
  AST_ACCEPT_ON_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_ale_o) |-> $past(req_valid_i && req_ready_o)); // R1
  AST_CS_IMPLIES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cs_o |-> busy_o); // R1
  AST_ALE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ale_o |=> !bus_ale_o); // R2
  AST_ALE_WITH_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ale_o |-> (bus_ad_oe_o && bus_cs_o)); // R2
  AST_RELEASE_AFTER_ALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_ale_o) |-> !bus_ad_oe_o); // R2
  AST_OE_INSIDE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> bus_cs_o); // R3
  AST_SAMPLE_UNDER_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> $past(bus_oe_o)); // R4
  AST_ERR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !req_ready_o); // R11
endmodule

bind pbus_rd_seq pbus_rd_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .cfg_err_o   (cfg_err_o),
  .busy_o      (busy_o),
  .bus_ale_o   (bus_ale_o),
  .bus_cs_o    (bus_cs_o),
  .bus_oe_o    (bus_oe_o),
  .bus_ad_oe_o (bus_ad_oe_o),
  .rsp_valid_o (rsp_valid_o)
);

// File: tb/sim_pbus_rd_seq.sv
`timescale 1ns/1ps
module sim_pbus_rd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int TW = 8;
  localparam int BEAT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] acc_first = 8'd3, acc_next = 8'd1, rd_setup = 8'd0, rd_hold = 8'd0, turn_off = 8'd2;
  logic bus16 = 1'b1;
  logic cfg_err;
  logic req_valid = 1'b0;
  logic [DATA_W-1:0] req_addr = '0;
  logic [BEAT_W-1:0] req_beats = '0;
  logic req_ready, busy, ale, cs, oe, ad_oe, rsp_valid, rsp_last;
  logic [2:0] bus_a;
  logic [DATA_W-1:0] bus_ad_o, bus_ad_i, rsp_data;

  int cyc = 0;
  int total = 0;
  int fails = 0;
  int cur_j = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) bus_ad_i <= {8'hC3, 8'(cyc)};

  pbus_rd_seq #(.DATA_W(DATA_W), .TW(TW), .BEAT_W(BEAT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_acc_first_i(acc_first), .cfg_acc_next_i(acc_next),
    .cfg_rd_setup_i(rd_setup), .cfg_rd_hold_i(rd_hold),
    .cfg_turn_off_i(turn_off), .cfg_bus16_i(bus16), .cfg_err_o(cfg_err),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_beats_i(req_beats),
    .req_ready_o(req_ready), .busy_o(busy),
    .bus_ale_o(ale), .bus_cs_o(cs), .bus_oe_o(oe), .bus_a_o(bus_a),
    .bus_ad_o(bus_ad_o), .bus_ad_oe_o(ad_oe), .bus_ad_i(bus_ad_i),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_last_o(rsp_last)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s (cycle %0d): got %h expected %h", req, what, cur_j, act, exp);
    end
  endtask

  // One read; leaves the bench at the negedge where the next request may be offered.
  task automatic run_read(input logic [15:0] addr, input int nb_m1, input int af, input int an,
                          input int su, input int hd, input int to, input bit b16, input bit twist);
    int ea, an_e, es, end_j, steps, nsmp, v;
    logic [15:0] dexp;
    logic [2:0] aexp;
    acc_first = TW'(af); acc_next = TW'(an); rd_setup = TW'(su);
    rd_hold = TW'(hd); turn_off = TW'(to); bus16 = b16;
    req_addr = addr; req_beats = BEAT_W'(nb_m1); req_valid = 1'b1;
    #1;
    cur_j = -1;
    chk("R1", "ready before request", req_ready, 1);
    @(posedge clk); #1;
    ea = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    if (twist) begin  // R12: alter settings mid-transfer, transfer must follow the old ones
      acc_first = 8'd7; acc_next = 8'd5; rd_setup = 8'd6; rd_hold = 8'd9; turn_off = 8'd12; bus16 = ~b16;
    end
    an_e = (an == 0) ? 1 : an;
    es = 1 + af + nb_m1 * an_e;
    end_j = es + to - 1;
    for (int j = 0; j <= end_j; j++) begin
      if (j > 0) @(negedge clk);
      cur_j = j;
      chk("R2", "ale", ale, (j == 0));
      chk("R2", "ad drive", ad_oe, (j == 0));
      if (j == 0) chk("R2", "address on bus", bus_ad_o, addr);
      if (j < es) begin
        chk(twist ? "R12" : "R3", "cs", cs, 1);
        chk("R3", "oe", oe, (j >= su));
        chk("R1", "busy", busy, 1);
      end else begin
        chk("R7", "cs hold", cs, (j < es + hd));
        chk("R6", "oe release", oe, 0);
        chk("R8", "busy gap", busy, (j < es + to - 1));
        chk("R8", "ready after gap", req_ready, (j >= es + to - 1));
      end
      nsmp = (j < 1 + af) ? 0 : ((j - 1 - af) / an_e + 1);
      if (nsmp > nb_m1 + 1) nsmp = nb_m1 + 1;
      if (j >= 1 + af && ((j - 1 - af) % an_e) == 0 && nsmp <= nb_m1 + 1 && j <= es) begin
        v = ea + j - 1;
        dexp = b16 ? {8'hC3, 8'(v)} : {8'h00, 8'(v)};
        chk(nsmp == 1 ? "R4" : "R5", "rsp_valid", rsp_valid, 1);
        chk(b16 ? "R4" : "R10", "rsp_data", rsp_data, dexp);
        chk("R5", "rsp_last", rsp_last, (j == es));
      end else begin
        chk(j < 1 + af ? "R4" : "R5", "no rsp", rsp_valid, 0);
      end
      if (j < es) begin
        steps = (nsmp > nb_m1) ? nb_m1 : nsmp;
        aexp = 3'(addr[2:0] + steps * (b16 ? 2 : 1));
        chk("R9", "low address", bus_a, aexp);
      end
    end
  endtask

  task automatic t_reset;
    cur_j = -1;
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset ready", req_ready, 1);
    chk("R2", "reset ale", ale, 0);
    chk("R2", "reset ad drive", ad_oe, 0);
    chk("R3", "reset cs", cs, 0);
    chk("R3", "reset oe", oe, 0);
    chk("R4", "reset rsp", rsp_valid, 0);
  endtask

  task automatic t_cfg_error;
    acc_first = 8'd3; rd_setup = 8'd3; rd_hold = 8'd0; turn_off = 8'd2;
    req_valid = 1'b1;
    #1;
    cur_j = -1;
    chk("R11", "err on setup order", cfg_err, 1);
    chk("R11", "ready blocked", req_ready, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cur_j = k;
      chk("R11", "cs idle", cs, 0);
      chk("R11", "ale idle", ale, 0);
      chk("R11", "busy idle", busy, 0);
    end
    rd_setup = 8'd1; rd_hold = 8'd2; turn_off = 8'd2;
    #1;
    chk("R11", "err on hold order", cfg_err, 1);
    @(negedge clk);
    chk("R11", "cs idle (hold)", cs, 0);
    req_valid = 1'b0;
    rd_hold = 8'd1;
    #1;
    chk("R11", "err cleared", cfg_err, 0);
    chk("R11", "ready back", req_ready, 1);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; total++;
    $display("FAIL watchdog: run did not complete, got hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_read(16'h1234, 0, 3, 1, 0, 0, 2, 1'b1, 1'b0);     // single beat, zero setup/hold
    run_read(16'hA5A6, 3, 4, 2, 2, 1, 3, 1'b1, 1'b0);     // 16-bit burst, address wraps
    run_read(16'h00F5, 2, 2, 0, 1, 2, 4, 1'b0, 1'b0);     // 8-bit, next-access 0 acts as 1
    run_read(16'h0007, 9, 1, 1, 0, 0, 1, 1'b0, 1'b0);     // long 8-bit burst, minimal gap
    run_read(16'h4442, 1, 2, 3, 1, 0, 1, 1'b1, 1'b0);     // back-to-back at earliest edge
    run_read(16'h0B0C, 2, 3, 2, 1, 2, 3, 1'b1, 1'b1);     // settings change mid-transfer
    t_cfg_error();
    run_read(16'hFFFF, 15, 2, 1, 1, 1, 2, 1'b1, 1'b0);    // full-length burst
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule